// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This block is a general-purpose I/O controller for up to 32 pins. It is driven through a plain register port: a valid strobe, a write flag, an address and 32-bit data. Each pin bit sits at the same position in every register. Per-pin registers choose the direction and an optional polarity inversion.

The output latch is never written directly. Software changes it only by writing masks to three strobe registers: one sets bits, one clears bits and one inverts bits. Pad inputs pass through a two-flop synchronizer. A registered copy of the synchronized value serves as the previous sample, and edges are found by comparing the two.

Each pin has its own rising-edge enable and falling-edge enable. Both can be on at once. An enabled edge latches a sticky status bit, and a cause register records whether that edge was rising or falling. Status bits are cleared by writing ones to them. A single interrupt line is high while any status bit is set.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is zero and `irq` is low, so all pins start as inputs.
- R2: Writing a mask to the set register (default offset 0x1C) makes every masked output-latch bit 1. Zero bits of the mask leave their latch bits unchanged. Register offsets are parameters.
- R3: Writing a mask to the reset register (default offset 0x20) makes every masked latch bit 0. Other bits are unchanged.
- R4: Writing a mask to the toggle register (default offset 0x24) inverts every masked latch bit.
- R5: In the direction register (default offset 0x14), bit value 1 makes a pin an output. `pad_oe` equals the direction register. `pad_out` equals the latch XOR the polarity register (default offset 0x18) for output pins, and is 0 for input pins.
- R6: The data register (default offset 0x10) reads the latch for output pins. For input pins it reads the pad value XOR polarity, which becomes visible two clock edges after the pad changes. Writes to the data register are ignored.
- R7: With its rising-enable bit set (register at default offset 0x08), a pin's status bit sets on the third clock edge after its polarity-adjusted input goes from 0 to 1. A change of polarity alone raises no event.
- R8: With its falling-enable bit set (register at default offset 0x0C), a pin's status bit sets on a polarity-adjusted 1-to-0 change. With both enables set, either edge sets it. A pin with neither enable set never sets its status bit.
- R9: Writing 1s to the status register (default offset 0x00) clears those bits, and 0 bits keep theirs. Writing back a value that was read clears exactly the pending bits.
- R10: If a new edge event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R11: The cause register (default offset 0x04) is read-only. On each latched event it records 1 for a rising edge or 0 for a falling edge, and it keeps that value until the pin's next event.
- R12: `irq` is high exactly when at least one status bit is set.
- R13: Bits at or above `NUM_PINS` read as zero in every register, ignore writes and pad activity, and keep `pad_oe` low. The set, reset and toggle registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address during a read, zero otherwise |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The status-clearing write and a freshly detected edge can act on the same status bit at the same clock edge. The bench first latches a pin's rising edge on a pin with both edge enables set. It then drops that pad and counts the two synchronizer stages, so that a write of 1 to that status bit is issued in exactly the cycle the falling edge is recognised. The check passes only if the bit is still set afterwards and the cause register shows a falling edge. A plain clear that follows must then empty the register and lower `irq`.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int unsigned REG_W = 32;

    typedef logic [REG_W-1:0] word_t;

    // Register selector, in register index order
    typedef enum logic [3:0] {
        RS_STATUS,
        RS_CAUSE,
        RS_RISE_EN,
        RS_FALL_EN,
        RS_DATA,
        RS_DIR,
        RS_POL,
        RS_SET,
        RS_RESET,
        RS_TOGGLE
    } reg_sel_e;

    // Mask with the lowest n bits set
    function automatic word_t pin_mask(int unsigned n);
        if (n >= REG_W) return '1;
        return (word_t'(1) << n) - word_t'(1);
    endfunction

endpackage

// File: rtl/gpio_in_stage.sv
module gpio_in_stage
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= pad_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
    end

    logic [W-1:0] prev_adj;

    // Both samples see the same polarity, so a polarity write cannot fake an edge
    always_comb begin
        level_o  = sync_q ^ pol_i;
        prev_adj = prev_q ^ pol_i;
        rise_o   = level_o & ~prev_adj;
        fall_o   = ~level_o & prev_adj;
    end

endmodule

// File: rtl/gpio_out_stage.sv
module gpio_out_stage
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         tgl_we,
    input  logic [W-1:0] bits_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] pad_out_o,
    output logic [W-1:0] pad_oe_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_o <= '0;
        end else if (set_we) begin
            latch_o <= latch_o | bits_i;
        end else if (clr_we) begin
            latch_o <= latch_o & ~bits_i;
        end else if (tgl_we) begin
            latch_o <= latch_o ^ bits_i;
        end
    end

    always_comb begin
        pad_out_o = (latch_o ^ pol_i) & dir_i;
        pad_oe_o  = dir_i;
    end

endmodule

// File: rtl/gpio_irq_stage.sv
module gpio_irq_stage
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] fall_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    input  logic         ack_we,
    input  logic [W-1:0] ack_bits,
    output logic [W-1:0] status_o,
    output logic [W-1:0] cause_o,
    output logic         irq_o
);

    logic [W-1:0] rise_hit;
    logic [W-1:0] event_hit;
    logic [W-1:0] ack_mask;

    always_comb begin
        rise_hit  = rise_i & rise_en_i;
        event_hit = rise_hit | (fall_i & fall_en_i);
        ack_mask  = ack_we ? ack_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            cause_o  <= '0;
        end else begin
            // A new event overrides a clear of the same bit
            status_o <= (status_o & ~ack_mask) | event_hit;
            cause_o  <= (cause_o & ~event_hit) | rise_hit;
        end
    end

    assign irq_o = |status_o;

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned          NUM_PINS   = 32,
    parameter int unsigned          ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]    OFS_STATUS = 'h00,
    parameter logic [ADDR_W-1:0]    OFS_CAUSE  = 'h04,
    parameter logic [ADDR_W-1:0]    OFS_RISE   = 'h08,
    parameter logic [ADDR_W-1:0]    OFS_FALL   = 'h0C,
    parameter logic [ADDR_W-1:0]    OFS_DATA   = 'h10,
    parameter logic [ADDR_W-1:0]    OFS_DIR    = 'h14,
    parameter logic [ADDR_W-1:0]    OFS_POL    = 'h18,
    parameter logic [ADDR_W-1:0]    OFS_SET    = 'h1C,
    parameter logic [ADDR_W-1:0]    OFS_RESET  = 'h20,
    parameter logic [ADDR_W-1:0]    OFS_TOGGLE = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [REG_W-1:0]  pad_in,
    output logic [REG_W-1:0]  pad_out,
    output logic [REG_W-1:0]  pad_oe,
    output logic              irq
);

    localparam word_t PIN_MASK = pin_mask(NUM_PINS);

    reg_sel_e sel;
    logic     sel_ok;
    logic     wr_en;
    word_t    wbits;

    always_comb begin
        sel_ok = 1'b1;
        sel    = RS_STATUS;
        if      (reg_addr == OFS_STATUS) sel = RS_STATUS;
        else if (reg_addr == OFS_CAUSE)  sel = RS_CAUSE;
        else if (reg_addr == OFS_RISE)   sel = RS_RISE_EN;
        else if (reg_addr == OFS_FALL)   sel = RS_FALL_EN;
        else if (reg_addr == OFS_DATA)   sel = RS_DATA;
        else if (reg_addr == OFS_DIR)    sel = RS_DIR;
        else if (reg_addr == OFS_POL)    sel = RS_POL;
        else if (reg_addr == OFS_SET)    sel = RS_SET;
        else if (reg_addr == OFS_RESET)  sel = RS_RESET;
        else if (reg_addr == OFS_TOGGLE) sel = RS_TOGGLE;
        else                             sel_ok = 1'b0;
    end

    assign wr_en = reg_valid && reg_write && sel_ok;
    assign wbits = reg_wdata & PIN_MASK;

    word_t rise_en_q, fall_en_q, dir_q, pol_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
            dir_q     <= '0;
            pol_q     <= '0;
        end else if (wr_en) begin
            unique case (sel)
                RS_RISE_EN: rise_en_q <= wbits;
                RS_FALL_EN: fall_en_q <= wbits;
                RS_DIR:     dir_q     <= wbits;
                RS_POL:     pol_q     <= wbits;
                default:    ;
            endcase
        end
    end

    word_t level, rise_l, fall_l;

    gpio_in_stage #(.W(REG_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_i   (pad_in & PIN_MASK),
        .pol_i   (pol_q),
        .level_o (level),
        .rise_o  (rise_l),
        .fall_o  (fall_l)
    );

    word_t out_latch;

    gpio_out_stage #(.W(REG_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (wr_en && sel == RS_SET),
        .clr_we    (wr_en && sel == RS_RESET),
        .tgl_we    (wr_en && sel == RS_TOGGLE),
        .bits_i    (wbits),
        .dir_i     (dir_q),
        .pol_i     (pol_q),
        .latch_o   (out_latch),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe)
    );

    word_t status, cause;

    gpio_irq_stage #(.W(REG_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise_l),
        .fall_i    (fall_l),
        .rise_en_i (rise_en_q),
        .fall_en_i (fall_en_q),
        .ack_we    (wr_en && sel == RS_STATUS),
        .ack_bits  (wbits),
        .status_o  (status),
        .cause_o   (cause),
        .irq_o     (irq)
    );

    word_t rd_word;

    always_comb begin
        unique case (sel)
            RS_STATUS:  rd_word = status;
            RS_CAUSE:   rd_word = cause;
            RS_RISE_EN: rd_word = rise_en_q;
            RS_FALL_EN: rd_word = fall_en_q;
            RS_DATA:    rd_word = (dir_q & out_latch) | (~dir_q & level);
            RS_DIR:     rd_word = dir_q;
            RS_POL:     rd_word = pol_q;
            default:    rd_word = '0;
        endcase
        reg_rdata = (reg_valid && !reg_write && sel_ok) ? (rd_word & PIN_MASK) : '0;
    end

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int unsigned       NUM_PINS   = 32,
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] OFS_STATUS = 'h00,
    parameter logic [ADDR_W-1:0] OFS_SET    = 'h1C,
    parameter logic [ADDR_W-1:0] OFS_RESET  = 'h20,
    parameter logic [ADDR_W-1:0] OFS_TOGGLE = 'h24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  pad_oe,
    input logic [REG_W-1:0]  latch,
    input logic [REG_W-1:0]  status,
    input logic [REG_W-1:0]  rise_en,
    input logic [REG_W-1:0]  fall_en,
    input logic [REG_W-1:0]  rise_l,
    input logic [REG_W-1:0]  fall_l
);

    localparam word_t MASK = pin_mask(NUM_PINS);

    logic  wr;
    word_t wm, ack, ev;

    always_comb begin
        wr  = reg_valid && reg_write;
        wm  = reg_wdata & MASK;
        ack = (wr && reg_addr == OFS_STATUS) ? reg_wdata : '0;
        ev  = (rise_l & rise_en) | (fall_l & fall_en);
    end

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_addr == OFS_SET) |=> ((latch & $past(wm)) == $past(wm))); // R2

    AST_RESET_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_addr == OFS_RESET) |=> ((latch & $past(wm)) == '0)); // R3

    AST_TOGGLE_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_addr == OFS_TOGGLE) |=> (latch == ($past(latch) ^ $past(wm)))); // R4

    AST_UNUSED_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~MASK) == '0) && ((status & ~MASK) == '0)); // R13

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~ack)) == $past(status & ~ack))); // R9

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((status & $past(ev)) == $past(ev))); // R10

    AST_NO_UNENABLED_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(rise_en | fall_en)) == '0)); // R8

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .NUM_PINS   (NUM_PINS),
    .ADDR_W     (ADDR_W),
    .OFS_STATUS (OFS_STATUS),
    .OFS_SET    (OFS_SET),
    .OFS_RESET  (OFS_RESET),
    .OFS_TOGGLE (OFS_TOGGLE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pad_oe    (pad_oe),
    .latch     (out_latch),
    .status    (status),
    .rise_en   (rise_en_q),
    .fall_en   (fall_en_q),
    .rise_l    (rise_l),
    .fall_l    (fall_l)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;

    localparam int unsigned NP = 24;
    localparam logic [31:0] M  = 32'h00FF_FFFF;
    localparam logic [7:0] A_STAT = 8'h00, A_CAUSE = 8'h04, A_RISE = 8'h08, A_FALL = 8'h0C,
                           A_DATA = 8'h10, A_DIR = 8'h14, A_POL = 8'h18, A_SET = 8'h1C,
                           A_RST = 8'h20, A_TGL = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;

    always #2.5 clk = ~clk;

    gpio_edge_ctrl #(.NUM_PINS(NP)) i_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #0.5 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_data(logic [31:0] o, logic [31:0] dr, logic [31:0] pl, logic [31:0] pd);
        return ((dr & o) | (~dr & (pd ^ pl))) & M;
    endfunction

    function automatic logic [31:0] exp_pad(logic [31:0] o, logic [31:0] dr, logic [31:0] pl);
        return (o ^ pl) & dr & M;
    endfunction

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, mo, md, mp, w;
        int unsigned seed;
        seed = 32'd4242;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, v);  chk("R1 status", v, 0);
        rd(A_CAUSE, v); chk("R1 cause", v, 0);
        rd(A_DIR, v);   chk("R1 dir", v, 0);
        rd(A_DATA, v);  chk("R1 data", v, 0);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R13 unused pins
        wr(A_DIR, 32'hFFFF_FFFF);
        rd(A_DIR, v);  chk("R13 dir upper", v, M);
        chk("R13 pad_oe upper", pad_oe, M);
        wr(A_DATA, 32'h0000_0123);
        rd(A_DATA, v); chk("R6 data write ignored", v, 0);
        wr(A_SET, 32'hFFFF_FFFF);
        rd(A_SET, v);  chk("R13 set reads zero", v, 0);
        rd(A_DATA, v); chk("R13 data upper", v, M);
        wr(A_RST, 32'hFFFF_FFFF);

        // R2 R3 R4 directed
        wr(A_SET, 32'h0000_00F0);
        rd(A_DATA, v); chk("R2 set", v, 32'h0000_00F0);
        wr(A_RST, 32'h0000_0030);
        rd(A_DATA, v); chk("R3 reset", v, 32'h0000_00C0);
        wr(A_TGL, 32'h0000_0F0F);
        rd(A_DATA, v); chk("R4 toggle", v, 32'h0000_0FCF);

        // R5 polarity on output path, R6 data returns latch for outputs
        wr(A_POL, 32'h0000_000F);
        @(negedge clk);
        chk("R5 pad_out", pad_out, 32'h0000_0FC0);
        rd(A_DATA, v); chk("R6 output reads latch", v, 32'h0000_0FCF);
        wr(A_DIR, 32'h00FF_0000);
        @(negedge clk);
        chk("R5 pad_oe", pad_oe, 32'h00FF_0000);
        chk("R5 pad_out inputs zero", pad_out, 0);

        // Random mix of latch and config writes (R2 R3 R4 R5 R6)
        wr(A_RST, 32'hFFFF_FFFF); wr(A_DIR, 0); wr(A_POL, 0);
        mo = 0; md = 0; mp = 0;
        for (int i = 0; i < 300; i++) begin
            w = $urandom();
            case ($urandom_range(4, 0))
                0: begin wr(A_SET, w); mo = mo | (w & M); end
                1: begin wr(A_RST, w); mo = mo & ~w; end
                2: begin wr(A_TGL, w); mo = mo ^ (w & M); end
                3: begin wr(A_DIR, w); md = w & M; end
                default: begin wr(A_POL, w); mp = w & M; end
            endcase
            rd(A_DATA, v);
            chk("R6 random data", v, exp_data(mo, md, mp, pad_in));
            chk("R5 random pad_out", pad_out, exp_pad(mo, md, mp));
        end

        // Edge interrupts: bit3 rise, bit5 fall, bit7 both
        wr(A_RST, 32'hFFFF_FFFF); wr(A_DIR, 0); wr(A_POL, 0);
        wr(A_RISE, 32'h0000_0088);
        wr(A_FALL, 32'h0000_00A0);
        @(negedge clk); pad_in = 32'h0000_00A8;
        @(negedge clk);
        rd(A_DATA, v);  chk("R6 input after two edges", v, 32'h0000_00A8);
        rd(A_STAT, v);  chk("R7 rising latched", v, 32'h0000_0088);
        chk("R12 irq high", {31'b0, irq}, 1);
        rd(A_CAUSE, v); chk("R11 cause rising", v, 32'h0000_0088);
        wr(A_STAT, 32'h0000_0008);
        rd(A_STAT, v);  chk("R9 partial clear", v, 32'h0000_0080);
        @(negedge clk); pad_in = 0;
        @(negedge clk); @(negedge clk);
        rd(A_STAT, v);  chk("R8 falling and both", v, 32'h0000_00A0);
        rd(A_CAUSE, v); chk("R11 cause falling", v, 32'h0000_0008);
        wr(A_CAUSE, 32'hFFFF_FFFF);
        rd(A_CAUSE, v); chk("R11 cause read-only", v, 32'h0000_0008);
        wr(A_STAT, 32'h0000_00A0);
        rd(A_STAT, v);  chk("R9 write-back clears", v, 0);
        chk("R12 irq low", {31'b0, irq}, 0);

        // R10 collision: clear and falling event on bit7 in one cycle
        @(negedge clk); pad_in = 32'h0000_0080;
        repeat (4) @(negedge clk);
        wr(A_STAT, 32'h0000_0080);
        @(negedge clk); pad_in = 0;
        @(negedge clk);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0000_0080;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        rd(A_STAT, v);  chk("R10 event wins over clear", v, 32'h0000_0080);
        rd(A_CAUSE, v); chk("R10 cause falling", v & 32'h80, 0);
        wr(A_STAT, 32'h0000_0080);
        rd(A_STAT, v);  chk("R9 clear after collision", v, 0);

        // R7 polarity: polarity change alone raises no event; inverted edges
        wr(A_POL, 32'h0000_0008);
        repeat (3) @(negedge clk);
        rd(A_STAT, v);  chk("R7 polarity change no event", v, 0);
        @(negedge clk); pad_in = 32'h0000_0008;
        repeat (3) @(negedge clk);
        rd(A_STAT, v);  chk("R7 inverted rise ignored", v, 0);
        @(negedge clk); pad_in = 0;
        @(negedge clk); @(negedge clk);
        rd(A_STAT, v);  chk("R7 inverted fall is rising", v, 32'h0000_0008);
        wr(A_STAT, 32'hFFFF_FFFF);

        // R13 upper enables dropped, upper pad activity ignored
        wr(A_RISE, 32'hFF00_0088);
        rd(A_RISE, v);  chk("R13 rise upper dropped", v, 32'h0000_0088);
        @(negedge clk); pad_in = 32'hFF00_0000;
        repeat (4) @(negedge clk);
        rd(A_STAT, v);  chk("R13 upper pads no event", v, 0);
        chk("R12 irq stays low", {31'b0, irq}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule